// File: doc/BRIEF.md
# Dual Alarm Comparator with Power-Off Control

This block watches the running calendar time of a real-time clock and compares it against two independently programmed alarm settings, each made of six packed-BCD fields (seconds, minutes, hours, day, month, year). The calendar counter supplies the current time together with a one-cycle update strobe. Only on that strobe is the comparison taken, and a match needs every one of the six fields to be equal: no field can be left out of the match. A match latches a per-alarm event flag that stays set until software clears it by writing a one to it.

Software programs the alarms, the interrupt enables, a wake enable for the first alarm and a power-off enable for the second alarm through a simple register write port. It reads them back through a registered read port. The block drives an alarm interrupt, a once-per-update timer interrupt and a wake request. It also drives an active-high power-enable pin for an external power-management IC. When the power-off enable is set, a match of the second alarm pulls that pin low, and it stays low until reset.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After a synchronous reset, irq_alarm, irq_timer and alarm_wake are 0, pmic_power_en is 1, and every register reads back 0.
- R2: When tick_i is 1 and all six fields of time_i equal the six fields of an alarm, that alarm's event flag is set. The first alarm's flag is status bit 6 and the second alarm's flag is status bit 7. The status register is at 0x44. The flag reads back 1 from the cycle after the strobe.
- R3: If any single field differs from the alarm, the flag is not set. time_i packs seconds in bits 7:0, then minutes, hours, day and month, with year in bits 47:40.
- R4: Without tick_i, a time equal to an alarm sets no flag.
- R5: irq_alarm equals (first flag AND enable bit 3) OR (second flag AND enable bit 4) of the enable register at 0x48. It follows that expression one clock later and stays high until the flag is cleared.
- R6: Writing 1 to a status flag bit clears it, and writing 0 leaves it unchanged. If a clearing write and a matching strobe fall in the same cycle, the flag ends up set.
- R7: With enable bit 2 set, irq_timer is high for exactly the one cycle after each tick_i. With bit 2 clear, irq_timer stays 0.
- R8: With bit 16 of the power register at 0x98 set, a match of the second alarm drives pmic_power_en low from the second cycle after the strobe. It stays low until reset, whatever later writes do. With bit 16 clear, a match leaves the pin high.
- R9: alarm_wake is the first alarm's flag ANDed with bit 1 of the wake register at 0x7C, registered one cycle later.
- R10: The alarm fields sit at 0x20 + 4*n for the first alarm and at 0x80 + 4*n for the second, where n runs from 0 for seconds to 5 for year. A read returns the written byte in rd_data one cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle calendar update strobe |
| time_i | input | FIELDS*FW (48) | Current time, packed BCD, seconds lowest |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (8) | Register write byte address |
| wr_data | input | DW (32) | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW (8) | Register read byte address |
| rd_data | output | DW (32) | Read data, valid the cycle after rd_en |
| irq_alarm | output | 1 | Combined alarm interrupt |
| irq_timer | output | 1 | Per-update timer interrupt |
| alarm_wake | output | 1 | Wake request from the first alarm |
| pmic_power_en | output | 1 | External power enable, low means power off |

## Verification
Two functions can meet in one cycle: a software write that clears a flag, and a matching update strobe that sets the same flag. The bench first sets the first alarm's flag. It then drives, on a single clock edge, a matching tick together with a write of 1 to that flag bit. It judges the result by reading status afterwards and expecting the flag still set. A second collision is an enable write together with an already pending flag: the interrupt must follow the new enable one clock later.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  // register byte offsets
  localparam int OFF_STATUS = 'h44;
  localparam int OFF_IEN    = 'h48;
  localparam int OFF_WAKE   = 'h7C;
  localparam int OFF_PWR    = 'h98;
  localparam int BASE_A     = 'h20;
  localparam int BASE_B     = 'h80;
  localparam int STRIDE     = 4;
  // bit positions
  localparam int B_TMR_EN   = 2;
  localparam int B_A_EN     = 3;
  localparam int B_B_EN     = 4;
  localparam int B_A_FLAG   = 6;
  localparam int B_B_FLAG   = 7;
  localparam int B_WAKE_EN  = 1;
  localparam int B_PWROFF   = 16;

  function automatic int field_off(input int bank, input int idx);
    return ((bank == 0) ? BASE_A : BASE_B) + STRIDE * idx;
  endfunction
endpackage

// File: rtl/rtc_alarm_bank.sv
module rtc_alarm_bank
  import rtc_alarm_pkg::*;
#(
  parameter int FIELDS = 6,
  parameter int FW     = 8,
  parameter int AW     = 8,
  parameter int BANK   = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [FW-1:0]        wr_field,
  input  logic [FIELDS*FW-1:0] now_i,
  output logic [FIELDS*FW-1:0] set_o,
  output logic                 hit_o
);
  logic [FIELDS-1:0] eq;

  for (genvar i = 0; i < FIELDS; i++) begin : g_fld
    localparam logic [AW-1:0] ADDR = AW'(field_off(BANK, i));
    logic [FW-1:0] fld_q;
    always_ff @(posedge clk) begin
      if (rst)                           fld_q <= '0;
      else if (wr_en && wr_addr == ADDR) fld_q <= wr_field;
    end
    assign set_o[i*FW +: FW] = fld_q;
    assign eq[i] = (fld_q == now_i[i*FW +: FW]);
  end

  assign hit_o = &eq;
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alarm_pkg::*;
#(
  parameter int FIELDS = 6,
  parameter int FW     = 8,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  input  logic [FIELDS*FW-1:0] time_i,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 rd_en,
  input  logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        rd_data,
  output logic                 irq_alarm,
  output logic                 irq_timer,
  output logic                 alarm_wake,
  output logic                 pmic_power_en
);
  localparam int NBANK = 2;
  localparam int TW    = FIELDS * FW;
  localparam logic [AW-1:0] A_STATUS = AW'(OFF_STATUS);
  localparam logic [AW-1:0] A_IEN    = AW'(OFF_IEN);
  localparam logic [AW-1:0] A_WAKE   = AW'(OFF_WAKE);
  localparam logic [AW-1:0] A_PWR    = AW'(OFF_PWR);

  logic [NBANK-1:0]    hit;
  logic [TW-1:0]       bank_set [NBANK];
  logic [NBANK-1:0]    flag_q, flag_d, clr, set;
  logic                en_tmr, en_a, en_b, wake_en, pwroff_en, off_q;
  logic                irq_a_q, irq_t_q, wake_q, pwr_q;
  logic [DW-1:0]       rd_q, rd_mux;
  logic                unused_wr;

  assign unused_wr = ^wr_data;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    rtc_alarm_bank #(.FIELDS(FIELDS), .FW(FW), .AW(AW), .BANK(g)) u_bank (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_field(wr_data[FW-1:0]), .now_i(time_i),
      .set_o(bank_set[g]), .hit_o(hit[g])
    );
  end

  // flag update: a matching strobe wins over a clearing write
  always_comb begin
    clr = '0;
    if (wr_en && wr_addr == A_STATUS)
      clr = {wr_data[B_B_FLAG], wr_data[B_A_FLAG]};
    set    = tick_i ? hit : '0;
    flag_d = (flag_q & ~clr) | set;
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == A_STATUS) begin
      rd_mux[B_A_FLAG] = flag_q[0];
      rd_mux[B_B_FLAG] = flag_q[1];
    end
    if (rd_addr == A_IEN) begin
      rd_mux[B_TMR_EN] = en_tmr;
      rd_mux[B_A_EN]   = en_a;
      rd_mux[B_B_EN]   = en_b;
    end
    if (rd_addr == A_WAKE) rd_mux[B_WAKE_EN] = wake_en;
    if (rd_addr == A_PWR)  rd_mux[B_PWROFF]  = pwroff_en;
    for (int b = 0; b < NBANK; b++)
      for (int i = 0; i < FIELDS; i++)
        if (rd_addr == AW'(field_off(b, i)))
          rd_mux = DW'(bank_set[b][i*FW +: FW]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q    <= '0;
      en_tmr    <= 1'b0;
      en_a      <= 1'b0;
      en_b      <= 1'b0;
      wake_en   <= 1'b0;
      pwroff_en <= 1'b0;
      off_q     <= 1'b0;
      irq_a_q   <= 1'b0;
      irq_t_q   <= 1'b0;
      wake_q    <= 1'b0;
      pwr_q     <= 1'b1;
      rd_q      <= '0;
    end else begin
      flag_q <= flag_d;
      if (wr_en && wr_addr == A_IEN) begin
        en_tmr <= wr_data[B_TMR_EN];
        en_a   <= wr_data[B_A_EN];
        en_b   <= wr_data[B_B_EN];
      end
      if (wr_en && wr_addr == A_WAKE) wake_en   <= wr_data[B_WAKE_EN];
      if (wr_en && wr_addr == A_PWR)  pwroff_en <= wr_data[B_PWROFF];
      if (tick_i && hit[1] && pwroff_en) off_q <= 1'b1;
      irq_a_q <= (flag_q[0] & en_a) | (flag_q[1] & en_b);
      irq_t_q <= tick_i & en_tmr;
      wake_q  <= flag_q[0] & wake_en;
      pwr_q   <= ~off_q;
      if (rd_en) rd_q <= rd_mux;
    end
  end

  assign rd_data       = rd_q;
  assign irq_alarm     = irq_a_q;
  assign irq_timer     = irq_t_q;
  assign alarm_wake    = wake_q;
  assign pmic_power_en = pwr_q;
endmodule

// File: rtl/rtc_alarm_unit_chk.sv
module rtc_alarm_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_i,
  input logic [1:0] flag,
  input logic       en_a,
  input logic       en_b,
  input logic       wake_en,
  input logic       irq_alarm,
  input logic       irq_timer,
  input logic       alarm_wake,
  input logic       pmic_power_en
);
  AST_PWR_STICKY: assert property (@(posedge clk) disable iff (rst)
    !pmic_power_en |=> !pmic_power_en); // R8
  AST_FLAG_A_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(flag[0]) |-> $past(tick_i)); // R4
  AST_FLAG_B_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(flag[1]) |-> $past(tick_i)); // R4
  AST_TMR_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
    irq_timer |-> $past(tick_i)); // R7
  AST_IRQ_FROM_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_alarm |-> $past((flag[0] & en_a) | (flag[1] & en_b))); // R5
  AST_WAKE_FROM_FLAG: assert property (@(posedge clk) disable iff (rst)
    alarm_wake |-> $past(flag[0] & wake_en)); // R9
endmodule

bind rtc_alarm_unit rtc_alarm_unit_chk u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .flag(flag_q),
  .en_a(en_a), .en_b(en_b), .wake_en(wake_en),
  .irq_alarm(irq_alarm), .irq_timer(irq_timer),
  .alarm_wake(alarm_wake), .pmic_power_en(pmic_power_en)
);

// File: tb/rtc_alarm_unit_bench.sv
module rtc_alarm_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] TA = 48'h99_12_31_23_59_45;
  localparam logic [47:0] TB = 48'h24_06_15_08_30_07;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic [47:0] time_i = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_alarm, irq_timer, alarm_wake, pmic_power_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_unit u_rtc_alarm_unit (
    .clk(clk), .rst(rst), .tick_i(tick_i), .time_i(time_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_alarm(irq_alarm), .irq_timer(irq_timer),
    .alarm_wake(alarm_wake), .pmic_power_en(pmic_power_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic tick(input logic [47:0] t);
    @(negedge clk);
    time_i = t; tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic program_alarms();
    for (int i = 0; i < 6; i++) begin
      wr(8'(8'h20 + 4*i), 32'(TA[i*8 +: 8]));
      wr(8'(8'h80 + 4*i), 32'(TB[i*8 +: 8]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_alarm", 32'(irq_alarm), 0);
    check("R1 irq_timer", 32'(irq_timer), 0);
    check("R1 alarm_wake", 32'(alarm_wake), 0);
    check("R1 pmic_power_en", 32'(pmic_power_en), 1);
    rd(8'h44, v); check("R1 status", v, 0);
    rd(8'h80, v); check("R1 alarm field", v, 0);

    program_alarms();
    // R10 readback
    for (int i = 0; i < 6; i++) begin
      rd(8'(8'h20 + 4*i), v); check("R10 first alarm field", v, 32'(TA[i*8 +: 8]));
      rd(8'(8'h80 + 4*i), v); check("R10 second alarm field", v, 32'(TB[i*8 +: 8]));
    end

    // R4 no strobe, equal time
    @(negedge clk); time_i = TA;
    repeat (4) @(negedge clk);
    rd(8'h44, v); check("R4 no tick no flag", v, 0);

    // R2/R3 sweep: f==6 means exact match
    for (int a = 0; a < 2; a++) begin
      for (int f = 0; f < 7; f++) begin
        logic [47:0] t;
        t = (a == 0) ? TA : TB;
        if (f < 6) t = t ^ (48'h1 << (8*f));
        tick(t);
        rd(8'h44, v);
        if (f == 6) check("R2 full match sets flag", v, (a == 0) ? 32'h40 : 32'h80);
        else        check("R3 single field mismatch", v, 0);
        wr(8'h44, 32'hC0);
      end
    end
    check("R5 enables off keep irq low", 32'(irq_alarm), 0);
    check("R8 power off disabled keeps pin high", 32'(pmic_power_en), 1);

    // R5 flag x enable sweep
    for (int fl = 1; fl < 4; fl++) begin
      wr(8'h48, 0);
      wr(8'h44, 32'hC0);
      if (fl[0]) tick(TA);
      if (fl[1]) tick(TB);
      for (int e = 0; e < 4; e++) begin
        wr(8'h48, 32'(e) << 3);
        @(negedge clk);
        check("R5 irq follows flags and enables", 32'(irq_alarm), 32'(|(fl & e)));
      end
    end

    // R6 clear semantics, enables A and B on
    wr(8'h48, 32'h18);
    wr(8'h44, 32'hC0);
    tick(TA);
    @(negedge clk);
    check("R5 irq after match", 32'(irq_alarm), 1);
    wr(8'h44, 32'h00);
    rd(8'h44, v); check("R6 writing zero keeps flag", v, 32'h40);
    check("R5 irq held while flag set", 32'(irq_alarm), 1);
    // R6 set wins over simultaneous clear
    @(negedge clk);
    time_i = TA; tick_i = 1'b1; wr_en = 1'b1; wr_addr = 8'h44; wr_data = 32'h40;
    @(negedge clk);
    tick_i = 1'b0; wr_en = 1'b0;
    rd(8'h44, v); check("R6 set wins over clear", v, 32'h40);
    wr(8'h44, 32'h40);
    rd(8'h44, v); check("R6 write one clears", v, 0);
    check("R5 irq drops after clear", 32'(irq_alarm), 0);

    // R7 timer pulse
    wr(8'h48, 32'h04);
    tick(TA ^ 48'h1);
    check("R7 timer high after tick", 32'(irq_timer), 1);
    @(negedge clk);
    check("R7 timer single cycle", 32'(irq_timer), 0);
    wr(8'h48, 0);
    tick(TA ^ 48'h1);
    check("R7 timer disabled", 32'(irq_timer), 0);

    // R9 wake
    tick(TA);
    wr(8'h7C, 32'h2);
    @(negedge clk);
    check("R9 wake with enable", 32'(alarm_wake), 1);
    wr(8'h7C, 0);
    @(negedge clk);
    check("R9 wake without enable", 32'(alarm_wake), 0);
    wr(8'h44, 32'hC0);

    // R8 power off
    wr(8'h98, 32'h1_0000);
    rd(8'h98, v); check("R10 power register readback", v, 32'h1_0000);
    tick(TB);
    check("R8 pin high one cycle after strobe", 32'(pmic_power_en), 1);
    @(negedge clk);
    check("R8 pin low after second alarm", 32'(pmic_power_en), 0);
    wr(8'h44, 32'hC0);
    wr(8'h98, 0);
    repeat (5) @(negedge clk);
    check("R8 pin stays low", 32'(pmic_power_en), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule